// File: doc/BRIEF.md
# Bus Register with Parallel Load, Serial Shift and All-Ones Preset

This block is a small storage register that hangs on a shared data bus. On a rising clock edge it can take a full word from its parallel inputs, take an all-ones word, or move its contents one place toward the serial output while a new bit enters at the far end. When no update is requested, it keeps its value.

A read enable controls the bus outputs. While the read enable is high, the register drives its stored word onto the bus. While it is low, the outputs float (high impedance), so several such registers can sit on one set of wires and take turns driving them.

Updates use a clock enable built from the write and shift requests. The register runs on a single free-running clock and the clock itself is never gated. The word width is a parameter; the default is 4 bits.

Top module: `busShiftReg`

## Requirements
- R1: While rstN is low at a rising clk edge, the stored word becomes all zeros.
- R2: With writeEn high and presetEn low, the stored word takes parIn on the rising edge.
- R3: With writeEn high and presetEn high, the stored word becomes all ones on the rising edge, whatever parIn is.
- R4: presetEn has no effect unless writeEn is high. With writeEn low, the register holds or shifts exactly as if presetEn were low.
- R5: With shiftEn high and writeEn low, each rising edge moves every bit from position i+1 to position i and loads serIn into bit WIDTH-1. serOut always shows bit 0 of the stored word.
- R6: With writeEn and shiftEn both low, the stored word does not change.
- R7: When writeEn and shiftEn are both high, the parallel or preset load is performed and no shift happens.
- R8: busOut carries the stored word while readEn is high and is high impedance (all z) while readEn is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| writeEn | input | 1 | Request a parallel or preset load |
| shiftEn | input | 1 | Request a one-place serial shift |
| presetEn | input | 1 | Load all ones instead of parIn when writeEn is high |
| readEn | input | 1 | Drive the stored word onto busOut |
| parIn | input | WIDTH | Parallel load data |
| serIn | input | 1 | Serial bit entering at the top position |
| serOut | output | 1 | Bit 0 of the stored word |
| busOut | output | WIDTH | Stored word when readEn is high, otherwise high impedance |

## Verification
The bench places two instances on one bus. It walks a serial stream through one of them bit by bit, so a wrong shift direction or a wrong serial entry point shows up on serOut and on the bus. Directed cases separate a preset load from a plain load by using a parIn that is not all ones. They also apply presetEn without writeEn, and apply both enables together, to separate the priority order from a shift. Random stimulus then alternates which register drives the bus, including cycles where neither does. A register that fails to release the bus shows up as a corrupted or non-floating bus value.

// File: rtl/busreg_pkg.sv
package busreg_pkg;
  typedef struct packed {
    logic advance;
    logic takeParallel;
    logic takeOnes;
    logic drive;
  } regStrobes_t;
endpackage

// File: rtl/busRegCtrl.sv
module busRegCtrl
  import busreg_pkg::*;
(
  input  logic        writeEn,
  input  logic        shiftEn,
  input  logic        presetEn,
  input  logic        readEn,
  output regStrobes_t strb
);
  always_comb begin
    strb.advance      = writeEn | shiftEn;
    strb.takeParallel = writeEn;
    strb.takeOnes     = writeEn & presetEn;
    strb.drive        = readEn;
  end
endmodule

// File: rtl/busRegDatapath.sv
module busRegDatapath
  import busreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobes_t      strb,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic [WIDTH-1:0] storedVal,
  output logic             serOut,
  output wire  [WIDTH-1:0] busOut
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] shiftedVal;
  logic [WIDTH-1:0] nextVal;

  for (genvar i = 0; i < WIDTH; i++) begin : g_shift
    if (i == TOP) begin : g_top
      assign shiftedVal[i] = serIn;
    end else begin : g_mid
      assign shiftedVal[i] = storedVal[i+1];
    end
  end

  always_comb begin
    if (strb.takeOnes)          nextVal = '1;
    else if (strb.takeParallel) nextVal = parIn;
    else                        nextVal = shiftedVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             storedVal <= '0;
    else if (strb.advance) storedVal <= nextVal;
  end

  assign serOut = storedVal[0];
  assign busOut = strb.drive ? storedVal : {WIDTH{1'bz}};
endmodule

// File: rtl/busShiftReg.sv
module busShiftReg
  import busreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             writeEn,
  input  logic             shiftEn,
  input  logic             presetEn,
  input  logic             readEn,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic             serOut,
  output wire  [WIDTH-1:0] busOut
);
  regStrobes_t      strb;
  logic [WIDTH-1:0] storedVal;

  busRegCtrl i_ctrl (
    .writeEn (writeEn),
    .shiftEn (shiftEn),
    .presetEn(presetEn),
    .readEn  (readEn),
    .strb    (strb)
  );

  busRegDatapath #(.WIDTH(WIDTH)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .parIn    (parIn),
    .serIn    (serIn),
    .storedVal(storedVal),
    .serOut   (serOut),
    .busOut   (busOut)
  );
endmodule

// File: rtl/busShiftReg_checker.sv
module busShiftReg_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             writeEn,
  input logic             shiftEn,
  input logic             presetEn,
  input logic [WIDTH-1:0] parIn,
  input logic             serIn,
  input logic             serOut,
  input logic [WIDTH-1:0] storedVal
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> storedVal == '0);

  assert_parallel_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn && !presetEn) |=> storedVal == $past(parIn));

  assert_preset_ones_R3: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn && presetEn) |=> storedVal == '1);

  assert_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !writeEn) |=>
      storedVal == {$past(serIn), $past(storedVal[WIDTH-1:1])});

  assert_serout_after_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !writeEn) |=> serOut == $past(storedVal[1]));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!writeEn && !shiftEn) |=> $stable(storedVal));
endmodule

bind busShiftReg busShiftReg_checker #(.WIDTH(WIDTH)) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .writeEn  (writeEn),
  .shiftEn  (shiftEn),
  .presetEn (presetEn),
  .parIn    (parIn),
  .serIn    (serIn),
  .serOut   (serOut),
  .storedVal(storedVal)
);

// File: tb/test_busShiftReg.sv
module test_busShiftReg;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic weA = 0, seA = 0, prA = 0, reA = 0, sinA = 0;
  logic weB = 0, seB = 0, prB = 0, reB = 0, sinB = 0;
  logic [W-1:0] parA = '0, parB = '0;
  logic soutA, soutB;
  wire  [W-1:0] sharedBus;

  logic [W-1:0] modelA = '0, modelB = '0;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  busShiftReg #(.WIDTH(W)) i_busShiftReg (
    .clk(clk), .rstN(rstN), .writeEn(weA), .shiftEn(seA), .presetEn(prA),
    .readEn(reA), .parIn(parA), .serIn(sinA), .serOut(soutA), .busOut(sharedBus)
  );

  busShiftReg #(.WIDTH(W)) i_busShiftRegPeer (
    .clk(clk), .rstN(rstN), .writeEn(weB), .shiftEn(seB), .presetEn(prB),
    .readEn(reB), .parIn(parB), .serIn(sinB), .serOut(soutB), .busOut(sharedBus)
  );

  function automatic logic [W-1:0] stepModel(input logic [W-1:0] cur, input logic rst,
      input logic we, input logic se, input logic pr, input logic [W-1:0] par,
      input logic sin);
    if (!rst)    return '0;
    if (we && pr) return '1;
    if (we)      return par;
    if (se)      return {sin, cur[W-1:1]};
    return cur;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkBus(input string tag);
    logic [W-1:0] exp;
    exp = reA ? modelA : (reB ? modelB : {W{1'bz}});
    check(sharedBus === exp, tag, sharedBus, exp);
    check(soutA === modelA[0], {tag, " serOut R5"}, {{(W-1){1'b0}}, soutA},
          {{(W-1){1'b0}}, modelA[0]});
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    modelA = stepModel(modelA, rstN, weA, seA, prA, parA, sinA);
    modelB = stepModel(modelB, rstN, weB, seB, prB, parB, sinB);
    #1;
    checkBus(tag);
    @(negedge clk);
  endtask

  task automatic idle();
    weA = 0; seA = 0; prA = 0; weB = 0; seB = 0; prB = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    reA = 1;
    cycle("R1 reset");
    cycle("R1 reset");
    rstN = 1;
    idle();
    cycle("R6 hold after reset");

    weA = 1; parA = 4'b1010;
    cycle("R2 load 1010");
    weA = 1; prA = 1; parA = 4'b0010;
    cycle("R3 preset with write");
    weA = 1; prA = 0; parA = 4'b0110;
    cycle("R2 load 0110");
    weA = 0; prA = 1;
    cycle("R4 preset alone holds");
    idle();
    cycle("R6 hold");

    seA = 1; prA = 1;
    foreach (parA[k]) begin
      sinA = k[0];
      cycle("R5 R4 shift with preset low-write");
    end
    prA = 0;
    sinA = 1;
    cycle("R5 shift");

    weA = 1; seA = 1; parA = 4'b1001; sinA = 0;
    cycle("R7 write beats shift");
    prA = 1;
    cycle("R7 preset beats shift");
    idle();

    reA = 0; reB = 0;
    cycle("R8 bus released");
    weB = 1; parB = 4'b0101; reB = 1;
    cycle("R8 peer drives");
    idle(); reB = 0; reA = 1;
    cycle("R8 first drives");

    for (int n = 0; n < 400; n++) begin
      logic [1:0] sel;
      weA = ($urandom % 4) == 0; seA = $urandom % 2; prA = $urandom % 2;
      parA = W'($urandom); sinA = $urandom % 2;
      weB = ($urandom % 4) == 0; seB = $urandom % 2; prB = $urandom % 2;
      parB = W'($urandom); sinB = $urandom % 2;
      sel = 2'($urandom % 3);
      reA = (sel == 2'd1); reB = (sel == 2'd2);
      cycle("R2 R3 R5 R6 R7 R8 random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule